// File: doc/BRIEF.md
# Endpoint Buffer-Ready Interrupt Status

This block keeps one sticky status flag for each endpoint of a seven-endpoint USB device controller. A flag goes high when the CPU-side buffer of that endpoint becomes available for the CPU or a DMA engine to read or write. Endpoints 1 to 6 report this with a one-cycle ready pulse. Endpoint 0 reports it through its buffer-valid flag, and only while the control transfer runs in the host-to-device (write) direction.

A mode input picks how flags are cleared. In hardware mode a flag drops when the matching buffer-valid flag falls, and CPU writes are ignored. In software mode the CPU clears a flag by writing 0 to its bit, while a 1 leaves the bit alone. The status word is visible on a port and through a CPU read at register offset 0x1A. A registered interrupt request combines all flags whose enable is set.

Top module: `bufrdy_irq_status`

## Requirements
- R1: For endpoints 1 to 6, a one-cycle `ep_rdy[n]` pulse sets status bit n at the next clock edge. `ep_rdy[0]` has no effect.
- R2: While `ep0_dir_rd` is 0, a 0-to-1 change of `buf_valid[0]` sets status bit 0 at the clock edge that first samples the new level.
- R3: While `ep0_dir_rd` is 1, status bit 0 is never set.
- R4: While `clr_by_sw` is 0, a 1-to-0 change of `buf_valid[n]` clears status bit n at the edge that first samples the low level. CPU writes leave the status unchanged in this mode.
- R5: While `clr_by_sw` is 1, a CPU write to offset 0x1A clears each status bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1. Falling `buf_valid` clears nothing in this mode.
- R6: When a set event and a clear (hardware or software) hit the same bit in the same cycle, the bit ends up set.
- R7: `irq_o` is a register. At each edge it takes the OR over n of (status bit n AND `irq_en[n]`), using the values present before that edge.
- R8: Status bits 15 to 7 always read 0. `cpu_rdata` returns the status word when `cpu_addr` is 0x1A and 0 otherwise. Writes to any other address have no effect.
- R9: A low `rst_n` clears the status and `irq_o` at once. `soft_rst` high at a clock edge clears both at that edge, and it takes priority over set events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, released synchronously |
| soft_rst | input | 1 | Synchronous software reset |
| ep_rdy | input | 7 | One-cycle buffer-ready pulses for endpoints 1 to 6 (bit 0 unused) |
| buf_valid | input | 7 | Buffer-valid flag for each endpoint |
| ep0_dir_rd | input | 1 | Endpoint 0 direction: 0 write, 1 read |
| clr_by_sw | input | 1 | Clear mode: 0 hardware clear, 1 software write-zero clear |
| irq_en | input | 7 | Interrupt enable for each endpoint |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 8 | CPU register offset |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data (combinational) |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The bench targets the cycles in which a set and a clear land on the same bit. A design that let the clear win would drop a ready event and leave the status at 0. It checks that CPU writes are ignored in hardware mode and that falling valid flags are ignored in software mode. A design that mixed up the two modes would clear bits in the wrong mode. It also checks that a write-one keeps its bit, which would catch a design that writes data straight into the register. Endpoint 0 is driven in both directions, which would catch a read-direction transfer that still raises a flag. The interrupt lag and masking are checked with the enables turned off, so a combinational or unmasked request would show up one cycle early or while disabled.

// File: rtl/bufrdy_pkg.sv
package bufrdy_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] STAT_OFFS = 8'h1A;
endpackage

// File: rtl/bufrdy_edge_det.sv
module bufrdy_edge_det #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_i;
  end

  always_comb begin
    rise_o = sig_i & ~sig_q;
    fall_o = ~sig_i & sig_q;
  end
endmodule

// File: rtl/bufrdy_stat_bit.sv
module bufrdy_stat_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  // a set beats a clear so that no ready event is lost
  always_comb begin
    if (soft_rst)   q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
    else            q_d = q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/bufrdy_irq_gen.sv
module bufrdy_irq_gen #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  logic irq_d;

  always_comb irq_d = soft_rst ? 1'b0 : |(stat_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end
endmodule

// File: rtl/bufrdy_irq_status.sv
module bufrdy_irq_status
  import bufrdy_pkg::*;
#(
  parameter int unsigned NUM_EP = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic [NUM_EP-1:0]    ep_rdy,
  input  logic [NUM_EP-1:0]    buf_valid,
  input  logic                 ep0_dir_rd,
  input  logic                 clr_by_sw,
  input  logic [NUM_EP-1:0]    irq_en,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [REG_W-1:0]     cpu_wdata,
  output logic [REG_W-1:0]     cpu_rdata,
  output logic [REG_W-1:0]     status_o,
  output logic                 irq_o
);
  localparam int unsigned PAD_W = REG_W - NUM_EP;

  logic [NUM_EP-1:0] v_rise, v_fall;
  logic [NUM_EP-1:0] set_vec, clr_vec, stat;
  logic              wr_hit;

  bufrdy_edge_det #(.W(NUM_EP)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (buf_valid),
    .rise_o (v_rise),
    .fall_o (v_fall)
  );

  always_comb begin
    wr_hit = cpu_we && (cpu_addr == STAT_OFFS);
    // endpoint 0 is driven by its valid flag, only for control writes
    set_vec    = ep_rdy;
    set_vec[0] = v_rise[0] & ~ep0_dir_rd;
    if (clr_by_sw) clr_vec = wr_hit ? ~cpu_wdata[NUM_EP-1:0] : '0;
    else           clr_vec = v_fall;
  end

  for (genvar n = 0; n < NUM_EP; n++) begin : g_bit
    bufrdy_stat_bit u_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .set_i    (set_vec[n]),
      .clr_i    (clr_vec[n]),
      .q_o      (stat[n])
    );
  end

  bufrdy_irq_gen #(.W(NUM_EP)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .stat_i   (stat),
    .en_i     (irq_en),
    .irq_o    (irq_o)
  );

  if (PAD_W > 0) begin : g_pad
    assign status_o = {{PAD_W{1'b0}}, stat};
  end else begin : g_nopad
    assign status_o = stat[REG_W-1:0];
  end

  assign cpu_rdata = (cpu_addr == STAT_OFFS) ? status_o : '0;
endmodule

// File: rtl/bufrdy_irq_status_chk.sv
module bufrdy_irq_status_chk
  import bufrdy_pkg::*;
#(
  parameter int unsigned NUM_EP = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [NUM_EP-1:0] ep_rdy,
  input logic [NUM_EP-1:0] buf_valid,
  input logic              ep0_dir_rd,
  input logic              clr_by_sw,
  input logic [NUM_EP-1:0] irq_en,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [REG_W-1:0]  cpu_wdata,
  input logic [REG_W-1:0]  cpu_rdata,
  input logic [REG_W-1:0]  status_o,
  input logic              irq_o
);
  logic [NUM_EP-1:0] v_seen;
  logic [NUM_EP-1:0] keep_q;
  logic [NUM_EP-1:0] keep_d;
  logic              started;

  // bits that no clearing source is allowed to drop at the next edge
  always_comb begin
    if (soft_rst)       keep_d = '0;
    else if (clr_by_sw) keep_d = status_o[NUM_EP-1:0] &
                                 ~((cpu_we && cpu_addr == STAT_OFFS) ? ~cpu_wdata[NUM_EP-1:0] : '0);
    else                keep_d = status_o[NUM_EP-1:0] & ~(v_seen & ~buf_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_seen  <= '0;
      keep_q  <= '0;
      started <= 1'b0;
    end else begin
      v_seen  <= buf_valid;
      keep_q  <= keep_d;
      started <= 1'b1;
    end
  end

  assert_rdy_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !soft_rst) |=> ((($past(ep_rdy) & ~status_o[NUM_EP-1:0]) >> 1) == '0));

  assert_ep0_rd_noset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ep0_dir_rd && !status_o[0]) |=> !status_o[0]);

  assert_no_stray_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((keep_q & ~status_o[NUM_EP-1:0]) == '0));

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[REG_W-1:NUM_EP] == '0);

  assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !soft_rst) |=> (irq_o == |($past(status_o[NUM_EP-1:0]) & $past(irq_en))));

  assert_soft_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status_o == '0 && !irq_o));
endmodule

bind bufrdy_irq_status bufrdy_irq_status_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .ep_rdy     (ep_rdy),
  .buf_valid  (buf_valid),
  .ep0_dir_rd (ep0_dir_rd),
  .clr_by_sw  (clr_by_sw),
  .irq_en     (irq_en),
  .cpu_we     (cpu_we),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .status_o   (status_o),
  .irq_o      (irq_o)
);

// File: tb/sim_bufrdy_irq_status.sv
module sim_bufrdy_irq_status;
  localparam int CLK_P = 10;
  localparam logic [7:0] OFFS = 8'h1A;

  typedef struct {
    logic [15:0] stat;
    logic        irq;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst;
  logic [6:0]  ep_rdy, buf_valid, irq_en;
  logic        ep0_dir_rd, clr_by_sw, cpu_we;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata, status_o;
  logic        irq_o;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t sb[$];

  logic [6:0] m_stat, m_vprev;

  always #(CLK_P/2) clk = ~clk;

  bufrdy_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ep_rdy(ep_rdy),
    .buf_valid(buf_valid), .ep0_dir_rd(ep0_dir_rd), .clr_by_sw(clr_by_sw),
    .irq_en(irq_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: inputs are already applied at a falling edge; predict and push
  task automatic tick(string tag);
    logic [6:0] rise, fall, setv, clrv, nxt;
    logic       irq_n;
    exp_t       e;
    rise = buf_valid & ~m_vprev;
    fall = ~buf_valid & m_vprev;
    setv = {ep_rdy[6:1], rise[0] & ~ep0_dir_rd};
    if (clr_by_sw) clrv = (cpu_we && cpu_addr == OFFS) ? ~cpu_wdata[6:0] : 7'h0;
    else           clrv = fall;
    nxt   = soft_rst ? 7'h0 : (setv | (m_stat & ~clrv));
    irq_n = soft_rst ? 1'b0 : |(m_stat & irq_en);
    m_stat  = nxt;
    m_vprev = buf_valid;
    e.stat = {9'h0, nxt};
    e.irq  = irq_n;
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
    ep_rdy   = '0;
    cpu_we   = 1'b0;
    soft_rst = 1'b0;
  endtask

  // monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " status"}, {16'h0, status_o}, {16'h0, e.stat});
      check({e.tag, " irq"}, {31'h0, irq_o}, {31'h0, e.irq});
    end
  end

  task automatic rd_check(logic [7:0] a, string tag);
    cpu_addr = a;
    #1;
    check(tag, {16'h0, cpu_rdata}, (a == OFFS) ? {25'h0, m_stat} : 32'h0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; ep_rdy = '0; buf_valid = '0; irq_en = 7'h7F;
    ep0_dir_rd = 1'b0; clr_by_sw = 1'b0; cpu_we = 1'b0; cpu_addr = OFFS; cpu_wdata = '0;
    m_stat = '0; m_vprev = '0;
    repeat (3) @(negedge clk);
    check("R9 reset status", {16'h0, status_o}, 32'h0);
    check("R9 reset irq", {31'h0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: ready pulses on EP3; EP0 pulse ignored
    ep_rdy = 7'b0001000; tick("R1 ep3 pulse");
    tick("R7 irq after ep3");
    ep_rdy = 7'b0000001; tick("R1 ep0 pulse ignored");
    // R4: hardware clear on falling valid
    buf_valid = 7'b0001000; tick("R4 valid high");
    buf_valid = 7'b0000000; tick("R4 valid falls clears ep3");
    tick("R7 irq drops");
    // R4: CPU write ignored in hardware mode
    ep_rdy = 7'b0100000; tick("R1 ep5 pulse");
    cpu_we = 1'b1; cpu_wdata = 16'h0000; tick("R4 write ignored");
    // R2: EP0 rising valid in write direction
    buf_valid = 7'b0000001; tick("R2 ep0 valid rise");
    buf_valid = 7'b0000000; tick("R4 ep0 valid fall");
    // R3: read direction never sets EP0
    ep0_dir_rd = 1'b1;
    buf_valid = 7'b0000001; tick("R3 ep0 read dir");
    buf_valid = 7'b0000000; tick("R3 ep0 read dir fall");
    ep0_dir_rd = 1'b0;
    // R6: hardware clear and set together
    buf_valid = 7'b0000100; tick("R6 prep valid ep2");
    ep_rdy = 7'b0000100; buf_valid = 7'b0000000; tick("R6 fall plus set ep2");
    // R5: software mode
    clr_by_sw = 1'b1;
    ep_rdy = 7'b0010010; tick("R5 set ep1 ep4");
    rd_check(OFFS, "R8 read status");
    rd_check(8'h1C, "R8 read other addr");
    cpu_addr = OFFS;
    cpu_we = 1'b1; cpu_wdata = 16'hFFFB; tick("R5 write0 clears ep2");
    buf_valid = 7'b0100000; tick("R5 valid high");
    buf_valid = 7'b0000000; tick("R5 falling valid no clear");
    cpu_we = 1'b1; cpu_addr = 8'h18; cpu_wdata = 16'h0000; tick("R8 write other addr");
    cpu_addr = OFFS;
    ep_rdy = 7'b0010000; cpu_we = 1'b1; cpu_wdata = 16'hFFEF; tick("R6 sw clear plus set ep4");
    // R7: masking by enables
    irq_en = 7'h00; tick("R7 disable all");
    tick("R7 irq masked");
    irq_en = 7'b0010000; tick("R7 enable ep4");
    tick("R7 irq via ep4");
    cpu_we = 1'b1; cpu_wdata = 16'h0000; tick("R5 clear all");
    tick("R7 irq low after clear");
    // R9: soft reset beats a set
    ep_rdy = 7'b1000000; tick("R1 ep6 pulse");
    ep_rdy = 7'b0000010; soft_rst = 1'b1; tick("R9 soft reset");
    rd_check(OFFS, "R8 read after soft reset");
    // R9: asynchronous hardware reset mid-run
    ep_rdy = 7'b0001000; tick("R1 ep3 again");
    tick("R7 irq before hw reset");
    rst_n = 1'b0;
    #1;
    check("R9 async status", {16'h0, status_o}, 32'h0);
    check("R9 async irq", {31'h0, irq_o}, 32'h0);
    m_stat = '0; m_vprev = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tick("R9 idle after reset");
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule